// File: doc/BRIEF.md
# UART Host Register Bank

This block is the byte-wide register file that a host processor sees when it drives a 16450/16550-style serial port. A 3-bit offset selects one of eight byte registers. A single-cycle write strobe or read strobe performs the access. Writes to the data offset queue bytes for the transmit serializer. Reads of the data offset take bytes that the receive deserializer has delivered. The line-control, interrupt-enable, FIFO-control, modem-control and scratch registers are held here, along with a 16-bit baud divisor. The divisor shares offsets 0 and 1 with the data and interrupt-enable registers and is visible only while line-control bit 7 is set.

Both data directions are buffered. In compatibility mode each buffer holds one byte. When FIFO-control bit 0 is set, each buffer holds sixteen bytes. The block builds the line status byte from the buffer fill levels and from sticky error flags. Those error flags clear when the line status register is read. Modem-status change bits collect in the same way and clear when read.

The bit clock, the shifters and the interrupt arbiter are outside this block. The block exchanges simple pulses and levels with them: a pop from the transmit buffer, a push into the receive buffer with its error flags, an idle flag from the transmit shifter, and the current interrupt identification code.

Top module: `uart_regbank`

## Requirements
- R1: After reset, LCR (offset 3) reads 0x03, LSR (offset 5) reads 0x60 while `shift_idle` is high, IER, MCR, MSR and scratch read 0x00, `divisor` is 0, and both buffers are empty.
- R2: While LCR bit 7 is 1, offset 0 reads and writes the divisor low byte and offset 1 the divisor high byte; the data buffer and IER are not touched; `divisor` = {high, low}.
- R3: A write to offset 0 with LCR bit 7 clear queues the byte for transmit (`tx_avail` high, `tx_data` = oldest byte), makes LSR bits 5 and 6 read 0, and clears `thre_pend`; `thre_pend` sets when `tx_pop` takes a byte; LSR bit 5 = transmit buffer empty, bit 6 = bit 5 and `shift_idle`.
- R4: A transmit write while the transmit buffer is full (and no pop in that cycle) replaces the newest entry and leaves the fill level unchanged.
- R5: Buffer depth is 16 while FIFO-control bit 0 is 1, else 1; a write to offset 2 that changes bit 0 empties both buffers; bits 7:6 appear on `rx_trig`.
- R6: A write to offset 2 with bit 1 set empties the receive buffer (LSR bit 0 reads 0); with bit 2 set it empties the transmit buffer; the other buffer keeps its contents.
- R7: A read of offset 0 with LCR bit 7 clear returns the oldest received byte and removes it, or returns 0x00 when empty; `rx_read_pulse` is high during that strobe; LSR bit 0 and `rx_ready` stay 1 while bytes remain.
- R8: A read of offset 5 returns LSR, then clears bits 1 to 4 and bit 7; an error raised in the same cycle as the read survives it.
- R9: A read of offset 6 returns the bits accumulated from `msr_set` and then clears them; offset 4 always reads 0x00; the scratch register at offset 7 reads back what was written.
- R10: A receive push into a full buffer with no pop in that cycle is discarded and sets LSR bit 1 (overrun) and bit 7; a push in the same cycle as a host read of a full buffer is kept.
- R11: A receive push carrying `rx_perr`, `rx_ferr` or `rx_brk` sets LSR bit 2, 3 or 4 respectively, together with LSR bit 7.
- R12: A read of offset 2 returns {FIFO enable, FIFO enable, 2'b00, `irq_id`}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 3 | Register offset |
| wdata | input | 8 | Write data |
| wr_stb | input | 1 | Single-cycle write strobe |
| rd_stb | input | 1 | Single-cycle read strobe |
| rdata | output | 8 | Read data, valid while `rd_stb` is high |
| tx_pop | input | 1 | Serializer takes the oldest transmit byte |
| shift_idle | input | 1 | Transmit shifter holds no character |
| rx_push | input | 1 | Deserializer delivers a byte |
| rx_byte | input | 8 | Delivered byte |
| rx_perr | input | 1 | Parity error with this byte |
| rx_ferr | input | 1 | Framing error with this byte |
| rx_brk | input | 1 | Break seen with this byte |
| msr_set | input | 8 | Modem status bits to accumulate |
| irq_id | input | 4 | Interrupt identification from the arbiter |
| divisor | output | 16 | Baud divisor |
| lcr_out | output | 8 | Line control register |
| ier_out | output | 4 | Interrupt enables |
| mcr_out | output | 5 | Modem control register |
| fifo_en | output | 1 | Sixteen-entry buffer mode |
| rx_trig | output | 2 | Receive trigger level field |
| tx_avail | output | 1 | Transmit buffer holds a byte |
| tx_data | output | 8 | Oldest transmit byte |
| thre_pend | output | 1 | Holding-register-empty event pending |
| rx_ready | output | 1 | Receive buffer holds a byte |
| rx_level | output | 5 | Receive buffer fill level |
| rx_read_pulse | output | 1 | Host is taking a received byte (restarts timeout) |

## Verification
Two pairs of functions can act in the same cycle. The host can read the line status while the deserializer pushes a byte with an error flag. The host can also pop a full receive buffer while a new byte arrives. The bench drives both strobes within one clock period. For the first pair it expects the read to return the old status and the new error to remain visible on the next read. For the second pair it expects the fill level to stay at sixteen with no overrun, and it then drains the buffer to confirm that the late byte was stored in order behind the others.

// File: rtl/uart_regbank_pkg.sv
package uart_regbank_pkg;

  typedef enum logic [2:0] {
    OFS_DATA    = 3'd0,
    OFS_IEN     = 3'd1,
    OFS_FIFO    = 3'd2,
    OFS_LINE    = 3'd3,
    OFS_MODEM   = 3'd4,
    OFS_LSTAT   = 3'd5,
    OFS_MSTAT   = 3'd6,
    OFS_SCRATCH = 3'd7
  } reg_ofs_e;

  localparam logic [7:0] LINE_CTL_RESET = 8'h03;

  // Sticky receive error flags, in the order they appear in the status byte.
  typedef struct packed {
    logic brk;
    logic frm;
    logic par;
    logic ovr;
  } line_err_t;

endpackage

// File: rtl/uart_fifo.sv
module uart_fifo #(
  parameter int DEPTH     = 16,
  parameter int WIDTH     = 8,
  parameter bit OVERWRITE = 1'b0
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       deep,
  input  logic                       flush,
  input  logic                       push,
  input  logic [WIDTH-1:0]           din,
  input  logic                       pop,
  output logic [WIDTH-1:0]           dout,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic                       full,
  output logic                       empty,
  output logic                       drop
);

  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [AW-1:0]    head_q, head_d, tail_q, tail_d;
  logic [CW-1:0]    cnt_q, cnt_d, cap;
  logic [WIDTH-1:0] mem [DEPTH];
  logic             do_push, do_pop, wr_en;
  logic [AW-1:0]    wr_idx;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p, input logic d);
    return d ? p + AW'(1) : '0;
  endfunction

  always_comb begin
    cap     = deep ? CW'(DEPTH) : CW'(1);
    empty   = (cnt_q == '0);
    full    = (cnt_q == cap);
    do_pop  = pop  & ~empty & ~flush;
    do_push = push & ~flush & (~full | do_pop);
    drop    = push & ~flush & full & ~do_pop;
  end

  always_comb begin
    head_d = head_q;
    tail_d = tail_q;
    cnt_d  = cnt_q;
    if (flush) begin
      head_d = '0;
      tail_d = '0;
      cnt_d  = '0;
    end else begin
      if (do_push) head_d = step(head_q, deep);
      if (do_pop)  tail_d = step(tail_q, deep);
      case ({do_push, do_pop})
        2'b10:   cnt_d = cnt_q + CW'(1);
        2'b01:   cnt_d = cnt_q - CW'(1);
        default: cnt_d = cnt_q;
      endcase
    end
  end

  generate
    if (OVERWRITE) begin : g_overwrite
      // A write into a full buffer lands on the newest slot.
      assign wr_en  = do_push | drop;
      assign wr_idx = do_push ? head_q : (deep ? head_q - AW'(1) : '0);
    end else begin : g_discard
      assign wr_en  = do_push;
      assign wr_idx = head_q;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else begin
      head_q <= head_d;
      tail_q <= tail_d;
      cnt_q  <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= din;
  end

  assign dout  = mem[tail_q];
  assign count = cnt_q;

endmodule

// File: rtl/uart_line_err.sv
module uart_line_err
  import uart_regbank_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  line_err_t set_i,
  input  logic      clr,
  output line_err_t err_o,
  output logic      any_o
);

  line_err_t err_q, err_d;
  logic      any_q, any_d;

  // A set in the clearing cycle wins over the clear.
  always_comb begin
    if (clr) begin
      err_d = set_i;
      any_d = |set_i;
    end else begin
      err_d = err_q | set_i;
      any_d = any_q | (|set_i);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q <= '0;
      any_q <= 1'b0;
    end else begin
      err_q <= err_d;
      any_q <= any_d;
    end
  end

  assign err_o = err_q;
  assign any_o = any_q;

endmodule

// File: rtl/uart_regbank.sv
module uart_regbank
  import uart_regbank_pkg::*;
#(
  parameter int BUF_DEPTH = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  addr,
  input  logic [7:0]  wdata,
  input  logic        wr_stb,
  input  logic        rd_stb,
  output logic [7:0]  rdata,
  input  logic        tx_pop,
  input  logic        shift_idle,
  input  logic        rx_push,
  input  logic [7:0]  rx_byte,
  input  logic        rx_perr,
  input  logic        rx_ferr,
  input  logic        rx_brk,
  input  logic [7:0]  msr_set,
  input  logic [3:0]  irq_id,
  output logic [15:0] divisor,
  output logic [7:0]  lcr_out,
  output logic [3:0]  ier_out,
  output logic [4:0]  mcr_out,
  output logic        fifo_en,
  output logic [1:0]  rx_trig,
  output logic        tx_avail,
  output logic [7:0]  tx_data,
  output logic        thre_pend,
  output logic        rx_ready,
  output logic [4:0]  rx_level,
  output logic        rx_read_pulse
);

  localparam int CNT_W = $clog2(BUF_DEPTH + 1);

  // Register state
  logic [7:0] lcr_q, lcr_d;
  logic [3:0] ier_q, ier_d;
  logic [4:0] mcr_q, mcr_d;
  logic [7:0] scr_q, scr_d;
  logic [7:0] dll_q, dll_d, dlm_q, dlm_d;
  logic       fen_q, fen_d;
  logic [1:0] trig_q, trig_d;
  logic [7:0] msr_q, msr_d;
  logic       thre_q, thre_d;

  // Decode
  logic dlab, sel_data, sel_ien;
  logic wr_thr, wr_dll, wr_dlm, wr_ier, wr_fcr, wr_lcr, wr_mcr, wr_scr;
  logic rd_rbr, rd_lsr, rd_msr;
  logic mode_flip, rx_flush, tx_flush;

  // Buffers
  logic [7:0]       rx_dout, tx_dout;
  logic [CNT_W-1:0] rx_cnt, tx_cnt;
  logic             rx_full, rx_empty, rx_drop;
  logic             tx_full, tx_empty, tx_ovw;

  // Status
  line_err_t err_set, err_q;
  logic      err_any;
  logic [7:0] lsr;
  logic [7:0] rd_mux;

  always_comb begin
    dlab     = lcr_q[7];
    sel_data = (addr == OFS_DATA);
    sel_ien  = (addr == OFS_IEN);
    wr_thr   = wr_stb & sel_data & ~dlab;
    wr_dll   = wr_stb & sel_data &  dlab;
    wr_ier   = wr_stb & sel_ien  & ~dlab;
    wr_dlm   = wr_stb & sel_ien  &  dlab;
    wr_fcr   = wr_stb & (addr == OFS_FIFO);
    wr_lcr   = wr_stb & (addr == OFS_LINE);
    wr_mcr   = wr_stb & (addr == OFS_MODEM);
    wr_scr   = wr_stb & (addr == OFS_SCRATCH);
    rd_rbr   = rd_stb & sel_data & ~dlab;
    rd_lsr   = rd_stb & (addr == OFS_LSTAT);
    rd_msr   = rd_stb & (addr == OFS_MSTAT);
    mode_flip = wr_fcr & (wdata[0] != fen_q);
    rx_flush  = wr_fcr & (wdata[1] | mode_flip);
    tx_flush  = wr_fcr & (wdata[2] | mode_flip);
  end

  uart_fifo #(.DEPTH(BUF_DEPTH), .WIDTH(8), .OVERWRITE(1'b1)) u_txbuf (
    .clk   (clk),
    .rst_n (rst_n),
    .deep  (fen_q),
    .flush (tx_flush),
    .push  (wr_thr),
    .din   (wdata),
    .pop   (tx_pop),
    .dout  (tx_dout),
    .count (tx_cnt),
    .full  (tx_full),
    .empty (tx_empty),
    .drop  (tx_ovw)
  );

  uart_fifo #(.DEPTH(BUF_DEPTH), .WIDTH(8), .OVERWRITE(1'b0)) u_rxbuf (
    .clk   (clk),
    .rst_n (rst_n),
    .deep  (fen_q),
    .flush (rx_flush),
    .push  (rx_push),
    .din   (rx_byte),
    .pop   (rd_rbr),
    .dout  (rx_dout),
    .count (rx_cnt),
    .full  (rx_full),
    .empty (rx_empty),
    .drop  (rx_drop)
  );

  always_comb begin
    err_set.ovr = rx_drop;
    err_set.par = rx_push & rx_perr;
    err_set.frm = rx_push & rx_ferr;
    err_set.brk = rx_push & rx_brk;
  end

  uart_line_err u_lerr (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (err_set),
    .clr   (rd_lsr),
    .err_o (err_q),
    .any_o (err_any)
  );

  // Next-state logic for the control registers
  always_comb begin
    lcr_d  = wr_lcr ? wdata      : lcr_q;
    ier_d  = wr_ier ? wdata[3:0] : ier_q;
    mcr_d  = wr_mcr ? wdata[4:0] : mcr_q;
    scr_d  = wr_scr ? wdata      : scr_q;
    dll_d  = wr_dll ? wdata      : dll_q;
    dlm_d  = wr_dlm ? wdata      : dlm_q;
    fen_d  = wr_fcr ? wdata[0]   : fen_q;
    trig_d = wr_fcr ? wdata[7:6] : trig_q;
    msr_d  = rd_msr ? msr_set : (msr_q | msr_set);
    if (wr_thr)                 thre_d = 1'b0;
    else if (tx_pop & ~tx_empty) thre_d = 1'b1;
    else                        thre_d = thre_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lcr_q  <= LINE_CTL_RESET;
      ier_q  <= '0;
      mcr_q  <= '0;
      scr_q  <= '0;
      dll_q  <= '0;
      dlm_q  <= '0;
      fen_q  <= 1'b0;
      trig_q <= '0;
      msr_q  <= '0;
      thre_q <= 1'b0;
    end else begin
      lcr_q  <= lcr_d;
      ier_q  <= ier_d;
      mcr_q  <= mcr_d;
      scr_q  <= scr_d;
      dll_q  <= dll_d;
      dlm_q  <= dlm_d;
      fen_q  <= fen_d;
      trig_q <= trig_d;
      msr_q  <= msr_d;
      thre_q <= thre_d;
    end
  end

  // Line status byte
  always_comb begin
    lsr[0]   = ~rx_empty;
    lsr[4:1] = err_q;
    lsr[5]   = tx_empty;
    lsr[6]   = tx_empty & shift_idle;
    lsr[7]   = err_any;
  end

  always_comb begin
    case (addr)
      OFS_DATA:    rd_mux = dlab ? dll_q : (rx_empty ? 8'h00 : rx_dout);
      OFS_IEN:     rd_mux = dlab ? dlm_q : {4'b0000, ier_q};
      OFS_FIFO:    rd_mux = {fen_q, fen_q, 2'b00, irq_id};
      OFS_LINE:    rd_mux = lcr_q;
      OFS_MODEM:   rd_mux = 8'h00;
      OFS_LSTAT:   rd_mux = lsr;
      OFS_MSTAT:   rd_mux = msr_q;
      default:     rd_mux = scr_q;
    endcase
  end

  assign rdata         = rd_stb ? rd_mux : 8'h00;
  assign divisor       = {dlm_q, dll_q};
  assign lcr_out       = lcr_q;
  assign ier_out       = ier_q;
  assign mcr_out       = mcr_q;
  assign fifo_en       = fen_q;
  assign rx_trig       = trig_q;
  assign tx_avail      = ~tx_empty;
  assign tx_data       = tx_dout;
  assign thre_pend     = thre_q;
  assign rx_ready      = ~rx_empty;
  assign rx_level      = 5'(rx_cnt);
  assign rx_read_pulse = rd_rbr;

endmodule

// File: rtl/uart_regbank_chk.sv
module uart_regbank_chk #(
  parameter int CW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic [2:0]    addr,
  input logic [7:0]    wdata,
  input logic          wr_stb,
  input logic          rd_stb,
  input logic          dlab,
  input logic          fen,
  input logic          tx_pop,
  input logic          rx_push,
  input logic [CW-1:0] tx_cnt,
  input logic [CW-1:0] rx_cnt,
  input logic          tx_full,
  input logic          tx_ovw,
  input logic          rx_full,
  input logic          tx_avail,
  input logic          thre_pend,
  input logic [3:0]    err_q,
  input logic [7:0]    msr_q,
  input logic [7:0]    msr_set
);

  a_r2_dlab_no_queue: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && addr == 3'd0 && dlab && !tx_pop) |=> $stable(tx_cnt));

  a_r3_thr_write_marks_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && addr == 3'd0 && !dlab) |=> (tx_avail && !thre_pend));

  a_r4_full_write_keeps_level: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ovw |=> (tx_full && $stable(tx_cnt)));

  a_r5_shallow_cap: assert property (@(posedge clk) disable iff (!rst_n)
    !fen |-> (tx_cnt <= CW'(1) && rx_cnt <= CW'(1)));

  a_r5_mode_flip_flushes: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && addr == 3'd2 && wdata[0] != fen) |=> (tx_cnt == '0 && rx_cnt == '0));

  a_r8_status_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && addr == 3'd5 && !rx_push) |=> (err_q == 4'b0000));

  a_r9_modem_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && addr == 3'd6 && msr_set == 8'h00) |=> (msr_q == 8'h00));

  a_r10_overrun_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_push && rx_full && !(rd_stb && addr == 3'd0 && !dlab) && !(wr_stb && addr == 3'd2))
      |=> err_q[0]);

endmodule

bind uart_regbank uart_regbank_chk #(.CW(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .addr      (addr),
  .wdata     (wdata),
  .wr_stb    (wr_stb),
  .rd_stb    (rd_stb),
  .dlab      (lcr_q[7]),
  .fen       (fen_q),
  .tx_pop    (tx_pop),
  .rx_push   (rx_push),
  .tx_cnt    (tx_cnt),
  .rx_cnt    (rx_cnt),
  .tx_full   (tx_full),
  .tx_ovw    (tx_ovw),
  .rx_full   (rx_full),
  .tx_avail  (tx_avail),
  .thre_pend (thre_pend),
  .err_q     (err_q),
  .msr_q     (msr_q),
  .msr_set   (msr_set)
);

// File: tb/uart_regbank_bench.sv
module uart_regbank_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic        wr_stb = 1'b0, rd_stb = 1'b0;
  logic [7:0]  rdata;
  logic        tx_pop = 1'b0, shift_idle = 1'b1;
  logic        rx_push = 1'b0;
  logic [7:0]  rx_byte = '0;
  logic        rx_perr = 1'b0, rx_ferr = 1'b0, rx_brk = 1'b0;
  logic [7:0]  msr_set = '0;
  logic [3:0]  irq_id = '0;
  logic [15:0] divisor;
  logic [7:0]  lcr_out;
  logic [3:0]  ier_out;
  logic [4:0]  mcr_out;
  logic        fifo_en;
  logic [1:0]  rx_trig;
  logic        tx_avail;
  logic [7:0]  tx_data;
  logic        thre_pend;
  logic        rx_ready;
  logic [4:0]  rx_level;
  logic        rx_read_pulse;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  uart_regbank u_uart_regbank (.*);

  typedef struct packed {
    logic       wr;
    logic [2:0] a;
    logic [7:0] d;
    logic [3:0] rq;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VT [NV] = '{
    '{1'b0, 3'd3, 8'h03, 4'd1},  // R1 line control reset value
    '{1'b0, 3'd5, 8'h60, 4'd1},  // R1 line status reset value
    '{1'b0, 3'd1, 8'h00, 4'd1},  // R1 interrupt enables
    '{1'b0, 3'd7, 8'h00, 4'd1},  // R1 scratch
    '{1'b0, 3'd6, 8'h00, 4'd1},  // R1 modem status
    '{1'b1, 3'd7, 8'hA5, 4'd9},  // R9 scratch write
    '{1'b0, 3'd7, 8'hA5, 4'd9},  // R9 scratch read back
    '{1'b1, 3'd4, 8'h1F, 4'd9},  // R9 modem control write
    '{1'b0, 3'd4, 8'h00, 4'd9},  // R9 modem control reads zero
    '{1'b1, 3'd3, 8'h83, 4'd2},  // R2 open divisor
    '{1'b1, 3'd0, 8'h34, 4'd2},  // R2 low byte
    '{1'b1, 3'd1, 8'h12, 4'd2},  // R2 high byte
    '{1'b0, 3'd0, 8'h34, 4'd2},  // R2
    '{1'b0, 3'd1, 8'h12, 4'd2},  // R2
    '{1'b0, 3'd5, 8'h60, 4'd2},  // R2 nothing queued
    '{1'b1, 3'd3, 8'h03, 4'd2},  // R2 close divisor
    '{1'b0, 3'd1, 8'h00, 4'd2},  // R2 enables untouched
    '{1'b1, 3'd1, 8'h0F, 4'd2},  // R2
    '{1'b0, 3'd1, 8'h0F, 4'd2},  // R2
    '{1'b0, 3'd3, 8'h03, 4'd2}   // R2
  };

  task automatic chk(input string rq, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", rq, act, exp, $time);
    end
  endtask

  task automatic reg_wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_stb = 1'b1;
    @(negedge clk);
    wr_stb = 1'b0;
  endtask

  task automatic reg_rd(input logic [2:0] a, input logic [7:0] exp, input string rq);
    @(negedge clk);
    addr = a; rd_stb = 1'b1;
    #1 chk(rq, 16'(rdata), 16'(exp));
    @(negedge clk);
    rd_stb = 1'b0;
  endtask

  task automatic rx_in(input logic [7:0] b, input logic pe, input logic fe, input logic bi);
    @(negedge clk);
    rx_push = 1'b1; rx_byte = b; rx_perr = pe; rx_ferr = fe; rx_brk = bi;
    @(negedge clk);
    rx_push = 1'b0; rx_perr = 1'b0; rx_ferr = 1'b0; rx_brk = 1'b0;
  endtask

  task automatic tx_take(input logic [7:0] exp, input string rq);
    @(negedge clk);
    #1 chk(rq, {8'h00, tx_avail, 7'h00, tx_data} , {8'h00, 1'b1, 7'h00, exp});
    tx_pop = 1'b1;
    @(negedge clk);
    tx_pop = 1'b0;
  endtask

  task automatic settle;
    @(negedge clk);
    #1;
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    settle();
    // R1 port state after reset
    chk("R1", divisor, 16'h0000);
    chk("R1", {15'h0, tx_avail}, 16'h0);
    chk("R1", {15'h0, rx_ready}, 16'h0);
    chk("R1", {11'h0, rx_level}, 16'h0);

    for (int i = 0; i < NV; i++) begin
      if (VT[i].wr) reg_wr(VT[i].a, VT[i].d);
      else          reg_rd(VT[i].a, VT[i].d, $sformatf("R%0d vec %0d", VT[i].rq, i));
    end
    settle();
    chk("R2", divisor, 16'h1234);
    chk("R2", {12'h0, ier_out}, 16'h000F);
    chk("R9", {11'h0, mcr_out}, 16'h001F);
    chk("R2", {8'h0, lcr_out}, 16'h0003);

    // R3 transmit queue and status bits
    reg_wr(0, 8'h41);
    settle();
    chk("R3", {7'h0, tx_avail, tx_data}, 16'h0141);
    chk("R3", {15'h0, thre_pend}, 16'h0);
    reg_rd(5, 8'h00, "R3");
    tx_take(8'h41, "R3");
    settle();
    chk("R3", {14'h0, thre_pend, tx_avail}, 16'h2);
    shift_idle = 1'b0;
    reg_rd(5, 8'h20, "R3");
    shift_idle = 1'b1;
    reg_rd(5, 8'h60, "R3");
    reg_wr(0, 8'h42);
    settle();
    chk("R3", {15'h0, thre_pend}, 16'h0);
    tx_take(8'h42, "R3");

    // R4 overwrite when full, shallow then deep
    reg_wr(0, 8'h11);
    reg_wr(0, 8'h22);
    tx_take(8'h22, "R4");
    settle();
    chk("R4", {15'h0, tx_avail}, 16'h0);
    reg_wr(2, 8'h01);
    settle();
    chk("R5", {15'h0, fifo_en}, 16'h1);
    for (int i = 0; i < 16; i++) reg_wr(0, 8'(i));
    reg_wr(0, 8'h99);
    for (int i = 0; i < 15; i++) tx_take(8'(i), "R4");
    tx_take(8'h99, "R4");
    settle();
    chk("R4", {15'h0, tx_avail}, 16'h0);

    // R7 receive pop order, pulse, empty read
    rx_in(8'hAA, 0, 0, 0);
    rx_in(8'hBB, 0, 0, 0);
    settle();
    chk("R7", {11'h0, rx_level}, 16'd2);
    @(negedge clk);
    addr = 3'd0; rd_stb = 1'b1;
    #1 chk("R7", {7'h0, rx_read_pulse, rdata}, 16'h01AA);
    @(negedge clk);
    rd_stb = 1'b0;
    #1 chk("R7", {14'h0, rx_read_pulse, rx_ready}, 16'h1);
    reg_rd(0, 8'hBB, "R7");
    settle();
    chk("R7", {15'h0, rx_ready}, 16'h0);
    reg_rd(0, 8'h00, "R7");

    // R10 push in same cycle as pop of a full buffer, then overrun
    for (int i = 0; i < 16; i++) rx_in(8'(8'h30 + i), 0, 0, 0);
    settle();
    chk("R10", {11'h0, rx_level}, 16'd16);
    @(negedge clk);
    addr = 3'd0; rd_stb = 1'b1; rx_push = 1'b1; rx_byte = 8'h77;
    #1 chk("R10", {8'h0, rdata}, 16'h0030);
    @(negedge clk);
    rd_stb = 1'b0; rx_push = 1'b0;
    #1 chk("R10", {11'h0, rx_level}, 16'd16);
    reg_rd(5, 8'h61, "R10");
    rx_in(8'h88, 0, 0, 0);
    reg_rd(5, 8'hE3, "R10");
    reg_rd(5, 8'h61, "R8");
    for (int i = 1; i < 16; i++) reg_rd(0, 8'(8'h30 + i), "R10");
    reg_rd(0, 8'h77, "R10");
    settle();
    chk("R10", {15'h0, rx_ready}, 16'h0);

    // R5 mode change flushes, shallow overrun
    rx_in(8'h01, 0, 0, 0);
    rx_in(8'h02, 0, 0, 0);
    reg_wr(2, 8'h00);
    settle();
    chk("R5", {10'h0, fifo_en, rx_ready, rx_level}, 16'h0);
    rx_in(8'h5A, 0, 0, 0);
    rx_in(8'h5B, 0, 0, 0);
    reg_rd(5, 8'hE3, "R5");
    reg_rd(0, 8'h5A, "R5");
    reg_rd(5, 8'h60, "R5");

    // R6 selective flush and trigger field
    reg_wr(2, 8'h01);
    rx_in(8'hD1, 0, 0, 0);
    rx_in(8'hD2, 0, 0, 0);
    reg_wr(0, 8'hC1);
    reg_wr(0, 8'hC2);
    reg_wr(2, 8'h03);
    settle();
    chk("R6", {11'h0, rx_level}, 16'd0);
    chk("R6", {15'h0, tx_avail}, 16'h1);
    reg_rd(5, 8'h00, "R6");
    reg_wr(2, 8'hC5);
    settle();
    chk("R6", {15'h0, tx_avail}, 16'h0);
    chk("R5", {13'h0, rx_trig, fifo_en}, 16'h7);

    // R8 error raised in the same cycle as a status read
    @(negedge clk);
    addr = 3'd5; rd_stb = 1'b1; rx_push = 1'b1; rx_byte = 8'hE1; rx_perr = 1'b1;
    #1 chk("R8", {8'h0, rdata}, 16'h0060);
    @(negedge clk);
    rd_stb = 1'b0; rx_push = 1'b0; rx_perr = 1'b0;
    reg_rd(5, 8'hE5, "R8");
    reg_rd(5, 8'h61, "R8");
    reg_rd(0, 8'hE1, "R8");

    // R11 framing and break flags
    rx_in(8'hF0, 0, 1, 1);
    reg_rd(5, 8'hF9, "R11");
    reg_rd(5, 8'h61, "R11");
    reg_rd(0, 8'hF0, "R11");

    // R9 modem status accumulates and clears on read
    @(negedge clk);
    msr_set = 8'h09;
    @(negedge clk);
    msr_set = 8'h02;
    @(negedge clk);
    msr_set = 8'h00;
    reg_rd(6, 8'h0B, "R9");
    reg_rd(6, 8'h00, "R9");

    // R12 identification read
    irq_id = 4'h4;
    reg_rd(2, 8'hC4, "R12");
    reg_wr(2, 8'h00);
    reg_rd(2, 8'h04, "R12");

    // R1 reset again mid-run
    reg_wr(3, 8'h9B);
    reg_wr(0, 8'h55);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    reg_rd(3, 8'h03, "R1");
    reg_rd(5, 8'h60, "R1");
    settle();
    chk("R1", divisor, 16'h0000);

    summary();
    $finish;
  end

endmodule